// File: doc/BRIEF.md
# RDS Block Synchronization Flywheel

This block decides whether an RDS/RBDS decoder is locked to the 26-bit block grid of the incoming stream. Upstream logic presents one event per received block: a syndrome-zero flag, the detected block type and a flag saying whether error correction changed bits that the demodulator rated as good. A saturating flywheel counter absorbs these events. Good blocks that arrive in the expected cyclic order raise it by two. Damaged or out-of-order blocks lower it by one. Type-E blocks leave it alone, which keeps the block usable for both the European and the North American variant.

From the counter the block derives a synchronized status, a data-valid qualifier for the block just received, and a one-cycle request that tells the acquisition logic to search for block boundaries again. It also decides whether each block goes to the host buffer, optionally only while synchronized, and keeps a buffer-not-empty interrupt flag that the host clears by reading.

The block events form a valid-only stream. The block has no ready output and applies no back-pressure: every cycle with `blk_valid` high is consumed in that cycle, so the upstream side may strobe on consecutive cycles. All outputs are registered and take the effect of a strobe one clock later. Reset is synchronous and active high.

Top module: `rds_flywheel_sync`

## Requirements
- R1: Block types are coded A=0, B=1, C=2, C'=3, D=4, E=5, and the cyclic order is A, B, C-or-C', D, then A again. While synchronized, a block with zero syndrome, no correction on good-rated bits and the expected type adds 2 to `fly_count`.
- R2: While synchronized, a block whose syndrome is nonzero, or whose correction touched good-rated bits, or that is clean but out of order, subtracts 1 from `fly_count`. The expected-type pointer advances on every strobe while synchronized, whether the block was good, bad or type E.
- R3: `fly_count` never exceeds 63. A good block at 62 or 63 leaves it at 63.
- R4: `synced` is high exactly when `fly_count` is nonzero. Counter and flags change one clock after a strobe and hold when no strobe arrives.
- R5: When a decrement brings the counter to zero, or when `resync` is high, the counter becomes 0 and `acq_req` is high for exactly one cycle. `resync` wins over a strobe in the same cycle.
- R6: While synchronized, a type-E block leaves `fly_count` unchanged.
- R7: `data_ok` is set after a good in-order block, or after a clean type-E block, only when the counter after the update is above 2. It is cleared by any block that decrements the counter, and it holds between strobes.
- R8: While `fly_count` is 0, the first strobe with zero syndrome, no correction on good-rated bits and type A to D loads the counter with 2. The next expected type is the one following it. Type-E or flawed blocks are ignored during acquisition.
- R9: `store_en` pulses for one cycle after each strobe that is stored. With `sync_only` low every strobe is stored. With `sync_only` high a block is stored only if the block is synchronized after its own update.
- R10: `bne_irq` is set when a block is stored and cleared one cycle after `host_read`. A store in the same cycle as `host_read` leaves it set.
- R11: After reset, `fly_count`, `synced`, `data_ok`, `acq_req`, `store_en` and `bne_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resync | input | 1 | Command to drop lock and restart acquisition |
| blk_valid | input | 1 | Block event strobe, one cycle per block |
| blk_syn_zero | input | 1 | Syndrome of the block is zero after correction |
| blk_good_corr | input | 1 | Correction changed bits rated as good |
| blk_type | input | 3 | Detected block type (A=0 .. E=5) |
| sync_only | input | 1 | Store blocks only while synchronized |
| host_read | input | 1 | Host has read the buffer; clears the interrupt |
| synced | output | 1 | Block synchronization held |
| data_ok | output | 1 | Data-valid qualifier for the last block |
| acq_req | output | 1 | One-cycle request to restart acquisition |
| store_en | output | 1 | One-cycle write enable for the last block |
| bne_irq | output | 1 | Buffer-not-empty interrupt flag |
| fly_count | output | 6 | Flywheel counter value |

## Verification
The bench pushes the counter to 62, 63 and one more good block to catch an increment that wraps to a small value instead of saturating. It places an E block inside a good run and checks both that the counter stays put and that the next B is still taken as in order, which a pointer that stalls on E would reject. A clean but out-of-order block must decrement, a design that only checks the syndrome would increment it. It also walks the counter down from 2 to 0 to see the single `acq_req` pulse, and it issues a read in the same cycle as a store, where a read-wins priority would lose the interrupt.

// File: rtl/rds_fw_pkg.sv
package rds_fw_pkg;

  localparam int SLOT_W = 2;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    BLK_A  = 3'd0,
    BLK_B  = 3'd1,
    BLK_C  = 3'd2,
    BLK_CP = 3'd3,
    BLK_D  = 3'd4,
    BLK_E  = 3'd5
  } blk_type_e;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_ACQ_HIT  = 3'd1,
    EV_ACQ_MISS = 3'd2,
    EV_GOOD     = 3'd3,
    EV_BAD      = 3'd4,
    EV_NEUTRAL  = 3'd5
  } fw_event_e;

  // Position of a type inside the four-slot cycle; C and C' share a slot.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [TYPE_W-1:0] t);
    case (t)
      BLK_A:         slot_of = 2'd0;
      BLK_B:         slot_of = 2'd1;
      BLK_C, BLK_CP: slot_of = 2'd2;
      default:       slot_of = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/rds_fw_classify.sv
module rds_fw_classify
  import rds_fw_pkg::*;
(
  input  logic                 blk_valid,
  input  logic                 blk_syn_zero,
  input  logic                 blk_good_corr,
  input  logic [TYPE_W-1:0]    blk_type,
  input  logic [SLOT_W-1:0]    exp_slot,
  input  logic                 acquiring,
  output fw_event_e            ev,
  output logic [SLOT_W-1:0]    slot,
  output logic                 clean
);

  logic is_abcd;
  logic is_e;

  always_comb begin
    clean   = blk_syn_zero && !blk_good_corr;
    is_abcd = (blk_type <= BLK_D);
    is_e    = (blk_type == BLK_E);
    slot    = slot_of(blk_type);
    if (!blk_valid)
      ev = EV_NONE;
    else if (acquiring)
      ev = (clean && is_abcd) ? EV_ACQ_HIT : EV_ACQ_MISS;
    else if (is_e)
      ev = EV_NEUTRAL;
    else if (clean && is_abcd && (slot == exp_slot))
      ev = EV_GOOD;
    else
      ev = EV_BAD;
  end

endmodule

// File: rtl/rds_fw_counter.sv
module rds_fw_counter
  import rds_fw_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int INC    = 2,
  parameter int DEC    = 1,
  parameter int LOAD   = 2,
  parameter int OK_THR = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 resync,
  input  fw_event_e            ev,
  input  logic [SLOT_W-1:0]    slot,
  input  logic                 clean,
  output logic [CNT_W-1:0]     cnt,
  output logic [SLOT_W-1:0]    exp_slot,
  output logic                 data_ok,
  output logic                 acq_req,
  output logic                 nxt_synced
);

  localparam int               CNT_MAX_I = (1 << CNT_W) - 1;
  localparam logic [CNT_W:0]   MAX_EXT   = (CNT_W+1)'(CNT_MAX_I);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(CNT_MAX_I);
  localparam logic [CNT_W-1:0] THR       = CNT_W'(OK_THR);
  localparam logic [CNT_W-1:0] LOAD_V    = CNT_W'(LOAD);
  localparam logic [CNT_W-1:0] DEC_V     = CNT_W'(DEC);

  logic [CNT_W:0]   inc_sum;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_dec;

  always_comb begin
    inc_sum = {1'b0, cnt} + (CNT_W+1)'(INC);
    cnt_inc = (inc_sum > MAX_EXT) ? CNT_MAX : inc_sum[CNT_W-1:0];
    cnt_dec = (cnt > DEC_V) ? (cnt - DEC_V) : '0;
    case (ev)
      EV_ACQ_HIT, EV_GOOD, EV_NEUTRAL: nxt_synced = 1'b1;
      EV_BAD:                          nxt_synced = (cnt_dec != '0);
      default:                         nxt_synced = (cnt != '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      exp_slot <= '0;
      data_ok  <= 1'b0;
      acq_req  <= 1'b0;
    end else if (resync) begin
      cnt      <= '0;
      exp_slot <= '0;
      data_ok  <= 1'b0;
      acq_req  <= 1'b1;
    end else begin
      acq_req <= 1'b0;
      case (ev)
        EV_ACQ_HIT: begin
          cnt      <= LOAD_V;
          exp_slot <= slot + 1'b1;
          data_ok  <= (LOAD_V > THR);
        end
        EV_GOOD: begin
          cnt      <= cnt_inc;
          exp_slot <= exp_slot + 1'b1;
          data_ok  <= (cnt_inc > THR);
        end
        EV_BAD: begin
          cnt      <= cnt_dec;
          exp_slot <= (cnt_dec == '0) ? '0 : exp_slot + 1'b1;
          data_ok  <= 1'b0;
          acq_req  <= (cnt_dec == '0);
        end
        EV_NEUTRAL: begin
          exp_slot <= exp_slot + 1'b1;
          data_ok  <= clean && (cnt > THR);
        end
        default: ;
      endcase
    end
  end

  // R6
  e_neutral_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_NEUTRAL && !resync) |=> $stable(cnt));

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_GOOD && cnt == CNT_MAX && !resync) |=> (cnt == CNT_MAX));

  // R5
  acq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    acq_req |-> (cnt == '0));

  // R7
  ok_thr_chk: assert property (@(posedge clk) disable iff (rst)
    data_ok |-> (cnt > THR));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_NONE && !resync) |=> ($stable(cnt) && $stable(data_ok)));

  // R2
  bad_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_BAD && !resync) |=> (cnt < $past(cnt)) && !data_ok);

endmodule

// File: rtl/rds_fw_store.sv
module rds_fw_store (
  input  logic clk,
  input  logic rst,
  input  logic resync,
  input  logic blk_valid,
  input  logic sync_only,
  input  logic nxt_synced,
  input  logic host_read,
  output logic store_en,
  output logic bne_irq
);

  logic store_now;

  always_comb
    store_now = blk_valid && !resync && (!sync_only || nxt_synced);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_en <= 1'b0;
      bne_irq  <= 1'b0;
    end else begin
      store_en <= store_now;
      if (store_now)
        bne_irq <= 1'b1;
      else if (host_read)
        bne_irq <= 1'b0;
    end
  end

  // R10
  bne_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (host_read && !store_now) |=> !bne_irq);

  // R10
  bne_set_chk: assert property (@(posedge clk) disable iff (rst)
    store_now |=> (bne_irq && store_en));

  // R9
  store_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && sync_only && !nxt_synced) |=> !store_en);

endmodule

// File: rtl/rds_flywheel_sync.sv
module rds_flywheel_sync
  import rds_fw_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int INC    = 2,
  parameter int DEC    = 1,
  parameter int LOAD   = 2,
  parameter int OK_THR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resync,
  input  logic             blk_valid,
  input  logic             blk_syn_zero,
  input  logic             blk_good_corr,
  input  logic [2:0]       blk_type,
  input  logic             sync_only,
  input  logic             host_read,
  output logic             synced,
  output logic             data_ok,
  output logic             acq_req,
  output logic             store_en,
  output logic             bne_irq,
  output logic [CNT_W-1:0] fly_count
);

  fw_event_e         ev;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] exp_slot;
  logic              clean;
  logic              nxt_synced;

  assign synced = (fly_count != '0);

  rds_fw_classify u_classify (
    .blk_valid     (blk_valid),
    .blk_syn_zero  (blk_syn_zero),
    .blk_good_corr (blk_good_corr),
    .blk_type      (blk_type),
    .exp_slot      (exp_slot),
    .acquiring     (!synced),
    .ev            (ev),
    .slot          (slot),
    .clean         (clean)
  );

  rds_fw_counter #(
    .CNT_W  (CNT_W),
    .INC    (INC),
    .DEC    (DEC),
    .LOAD   (LOAD),
    .OK_THR (OK_THR)
  ) u_counter (
    .clk        (clk),
    .rst        (rst),
    .resync     (resync),
    .ev         (ev),
    .slot       (slot),
    .clean      (clean),
    .cnt        (fly_count),
    .exp_slot   (exp_slot),
    .data_ok    (data_ok),
    .acq_req    (acq_req),
    .nxt_synced (nxt_synced)
  );

  rds_fw_store u_store (
    .clk        (clk),
    .rst        (rst),
    .resync     (resync),
    .blk_valid  (blk_valid),
    .sync_only  (sync_only),
    .nxt_synced (nxt_synced),
    .host_read  (host_read),
    .store_en   (store_en),
    .bne_irq    (bne_irq)
  );

  // R8
  acq_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!synced && ev == EV_ACQ_HIT && !resync) |=> (fly_count == CNT_W'(LOAD)));

endmodule

// File: tb/tb_rds_flywheel_sync.sv
module tb_rds_flywheel_sync;

  logic       clk = 1'b0;
  logic       rst, resync, blk_valid, blk_syn_zero, blk_good_corr;
  logic [2:0] blk_type;
  logic       sync_only, host_read;
  logic       synced, data_ok, acq_req, store_en, bne_irq;
  logic [5:0] fly_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rds_flywheel_sync dut (
    .clk(clk), .rst(rst), .resync(resync), .blk_valid(blk_valid),
    .blk_syn_zero(blk_syn_zero), .blk_good_corr(blk_good_corr),
    .blk_type(blk_type), .sync_only(sync_only), .host_read(host_read),
    .synced(synced), .data_ok(data_ok), .acq_req(acq_req),
    .store_en(store_en), .bne_irq(bne_irq), .fly_count(fly_count)
  );

  // {resync, valid, syn_zero, good_corr, type[2:0], cnt[5:0], synced, ok, acq}
  localparam int NV = 19;
  localparam logic [15:0] VEC [NV] = '{
    {4'b0110, 3'd0,  6'd2, 3'b100},  // R8 first A loads 2
    {4'b0110, 3'd1,  6'd4, 3'b110},  // R1 B, ok
    {4'b0110, 3'd3,  6'd6, 3'b110},  // R1 C'
    {4'b0110, 3'd4,  6'd8, 3'b110},  // R1 D
    {4'b0110, 3'd5,  6'd8, 3'b110},  // R6 E neutral
    {4'b0110, 3'd1,  6'd10, 3'b110}, // R2 pointer stepped past E
    {4'b0100, 3'd2,  6'd9, 3'b100},  // R2 bad syndrome
    {4'b0111, 3'd4,  6'd8, 3'b100},  // R2 good-bit correction
    {4'b0110, 3'd2,  6'd7, 3'b100},  // R2 clean out of order
    {4'b0000, 3'd0,  6'd7, 3'b100},  // R4 idle hold
    {4'b0110, 3'd1,  6'd9, 3'b110},  // R7 ok returns above 2
    {4'b1000, 3'd0,  6'd0, 3'b001},  // R5 resync
    {4'b0000, 3'd0,  6'd0, 3'b000},  // R5 pulse ends
    {4'b0110, 3'd5,  6'd0, 3'b000},  // R8 E ignored in acquisition
    {4'b0100, 3'd2,  6'd0, 3'b000},  // R8 flawed ignored
    {4'b0110, 3'd4,  6'd2, 3'b100},  // R8 D acquires
    {4'b0100, 3'd0,  6'd1, 3'b100},  // R2 drop to 1
    {4'b0100, 3'd1,  6'd0, 3'b001},  // R5 lost, request
    {4'b0000, 3'd0,  6'd0, 3'b000}   // R5 single cycle
  };
  localparam int VTAG [NV] = '{8,1,1,1,6,2,2,2,2,4,7,5,5,8,8,8,2,5,5};

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic blk(input logic rs, input logic v, input logic sz,
                     input logic cr, input logic [2:0] t);
    resync = rs; blk_valid = v; blk_syn_zero = sz; blk_good_corr = cr; blk_type = t;
    step();
    resync = 0; blk_valid = 0; blk_syn_zero = 0; blk_good_corr = 0; blk_type = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    resync = 0; blk_valid = 0; blk_syn_zero = 0; blk_good_corr = 0;
    blk_type = 0; sync_only = 0; host_read = 0; rst = 1;
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11", {fly_count, synced, data_ok, acq_req, store_en, bne_irq}, 0, "reset outputs");

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      blk(v[15], v[14], v[13], v[12], v[11:9]);
      checks++;
      if ({fly_count, synced, data_ok, acq_req} != v[8:0]) begin
        failures++;
        $display("FAIL R%0d vector %0d actual cnt=%0d s=%0b ok=%0b acq=%0b expected cnt=%0d s=%0b ok=%0b acq=%0b",
                 VTAG[i], i, fly_count, synced, data_ok, acq_req,
                 v[8:3], v[2], v[1], v[0]);
      end
    end

    // R3 saturation at 63
    do_reset();
    blk(0, 1, 1, 0, 3'd0);
    for (int k = 1; k <= 32; k++) begin
      logic [2:0] t;
      t = (k % 4 == 3) ? 3'd4 : 3'(k % 4);
      blk(0, 1, 1, 0, t);
      if (k == 30) chk("R3", fly_count, 62, "count before saturation");
      if (k == 31) chk("R3", fly_count, 63, "count saturates");
    end
    chk("R3", fly_count, 63, "count held at max");
    chk("R7", data_ok, 1, "ok at max");

    // R9 sync-only storage
    do_reset();
    sync_only = 1;
    blk(0, 1, 1, 0, 3'd5);
    chk("R9", {store_en, bne_irq}, 0, "unsynced block not stored");
    blk(0, 1, 1, 0, 3'd0);
    chk("R9", store_en, 1, "acquiring block stored");
    chk("R10", bne_irq, 1, "irq set on store");
    step();
    chk("R9", store_en, 0, "store is one pulse");
    chk("R10", bne_irq, 1, "irq held");
    host_read = 1; step(); host_read = 0;
    chk("R10", bne_irq, 0, "irq cleared by read");

    // R9 store everything when sync_only is low
    sync_only = 0;
    blk(1, 0, 0, 0, 3'd0);
    blk(0, 1, 0, 0, 3'd2);
    chk("R9", {store_en, bne_irq}, 3, "flawed block stored without sync-only");
    host_read = 1;
    blk(0, 1, 0, 0, 3'd1);
    chk("R10", bne_irq, 1, "store wins over read");
    step();
    host_read = 0;
    chk("R10", bne_irq, 0, "read alone clears");

    finish_run();
  end

endmodule